// File: doc/BRIEF.md
# DMA Burst and Chunk Segmenter

This block divides one microblock of a DMA channel into bus transactions. It takes an element count and produces a stream of burst commands. Each command carries a length. Two flags mark the command that closes a peripheral chunk and the command that closes the microblock. It does not generate addresses and it does not move data. A downstream address and data engine takes each command through a valid/ready handshake.

There are two modes. In self-triggered (memory-to-memory) mode the segmenter issues bursts back to back. Each burst is as long as the channel's burst limit allows, and the last one is shortened to cover whatever is left. In hardware-synchronized mode every chunk waits for a rising edge on the peripheral request line. A chunk has a programmable size, and the last chunk is shorter when the length does not divide evenly. Each chunk is then issued as one or more bursts, and no burst straddles a chunk boundary.

Top module: `burst_chunk_seg`

## Requirements
- R1: After reset `cmd_valid_o` and `busy_o` are low.
- R2: A `start_i` pulse with `ublk_len_i` equal to 0 is ignored: `busy_o` stays low and no command is issued.
- R3: In self-triggered mode (`hw_sync_i`=0) the first command is valid in the cycle after the start edge, with no peripheral request needed.
- R4: Every command length is at least 1 and at most the burst limit. The burst limit is selected by `burst_sel_i`: 0→1, 1→4, 2→8, 3→16 elements. In self-triggered mode each command is min(limit, elements remaining).
- R5: When the microblock length is not a multiple of the burst limit, one shorter final burst carries the remainder, and the command lengths sum to `ublk_len_i`.
- R6: In hardware-synchronized mode (`hw_sync_i`=1) no command is issued until a rising edge of `periph_req_i`. That edge admits a chunk of min(chunk size, elements remaining). The chunk size is selected by `chunk_sel_i`: 0→1, 1→2, 2→4, 3→8, 4 to 7→16 elements.
- R7: Within a chunk, bursts are min(burst limit, elements left in the chunk), and no burst crosses a chunk boundary. `cmd_eoc_o` is high only on the last burst of a chunk and is always low in self-triggered mode. After that burst, no command is issued until the next request edge.
- R8: When the microblock length is not a multiple of the chunk size, the last chunk is shorter and holds the remainder.
- R9: A request edge that arrives while a chunk is still issuing is ignored. A request held high across the end of a chunk does not admit the next chunk; a fresh rising edge is needed.
- R10: `cmd_eom_o` is high only on the command that carries the last element. Once that command is accepted, the block returns to idle (`busy_o` low).
- R11: While `cmd_valid_o` is high and `cmd_ready_i` is low, the command (valid, length, flags) holds unchanged.
- R12: `start_i` is ignored while `busy_o` is high. The configuration captured at the accepted start stays in force until the microblock ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a microblock (accepted when idle) |
| ublk_len_i | input | LEN_W | Microblock element count |
| burst_sel_i | input | 2 | Burst limit select |
| chunk_sel_i | input | 3 | Chunk size select |
| hw_sync_i | input | 1 | 1 = request-paced, 0 = self-triggered |
| periph_req_i | input | 1 | Peripheral request level (edge-detected) |
| cmd_ready_i | input | 1 | Downstream accepts command |
| cmd_valid_o | output | 1 | Command valid |
| cmd_len_o | output | 5 | Burst length in elements |
| cmd_eoc_o | output | 1 | Last burst of a chunk |
| cmd_eom_o | output | 1 | Last burst of the microblock |
| busy_o | output | 1 | Microblock in progress |

## Verification
A corrupted remaining-element counter shows at the ports on the next accepted command. The length is wrong, `cmd_eom_o` arrives early or late, or `busy_o` fails to fall after the final command. A lost or stale chunk counter shows as a burst that crosses a chunk boundary or as a misplaced `cmd_eoc_o`. The bench compares every command against lengths it computes from the requirements, so such faults surface within one handshake. A wrong state or edge-detector register shows as a command that appears without a request edge, or one that never appears. The bench checks this in the cycles before and after each request pulse.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int SEG_LEN_MAX = 16;
  localparam int SEG_CMD_W   = $clog2(SEG_LEN_MAX + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_ISSUE} seg_state_e;

  function automatic logic [SEG_CMD_W-1:0] burst_decode(input logic [1:0] sel);
    case (sel)
      2'd0:    return SEG_CMD_W'(1);
      2'd1:    return SEG_CMD_W'(4);
      2'd2:    return SEG_CMD_W'(8);
      default: return SEG_CMD_W'(16);
    endcase
  endfunction

  function automatic logic [SEG_CMD_W-1:0] chunk_decode(input logic [2:0] sel);
    if (sel >= 3'd4) return SEG_CMD_W'(16);
    return SEG_CMD_W'(1) << sel;
  endfunction
endpackage

// File: rtl/seg_edge_det.sv
module seg_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;

  // a level held high yields a single rise
  p_single_rise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/seg_len_pick.sv
module seg_len_pick #(
  parameter int LEN_W = 16,
  parameter int CMD_W = 5
) (
  input  logic [CMD_W-1:0] lim_i,
  input  logic [LEN_W-1:0] rem_i,
  output logic [CMD_W-1:0] len_o
);
  always_comb begin
    if (LEN_W'(lim_i) < rem_i) len_o = lim_i;
    else                       len_o = rem_i[CMD_W-1:0];
  end
endmodule

// File: rtl/burst_chunk_seg.sv
module burst_chunk_seg
  import seg_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [LEN_W-1:0]     ublk_len_i,
  input  logic [1:0]           burst_sel_i,
  input  logic [2:0]           chunk_sel_i,
  input  logic                 hw_sync_i,
  input  logic                 periph_req_i,
  input  logic                 cmd_ready_i,
  output logic                 cmd_valid_o,
  output logic [SEG_CMD_W-1:0] cmd_len_o,
  output logic                 cmd_eoc_o,
  output logic                 cmd_eom_o,
  output logic                 busy_o
);
  localparam int CMD_W = SEG_CMD_W;

  seg_state_e       state_q;
  logic [LEN_W-1:0] rem_ublk_q;
  logic [CMD_W-1:0] rem_chunk_q, bmax_q, cmax_q;
  logic             hw_q;

  logic             req_rise, fire, accept;
  logic [CMD_W-1:0] blen, chunk_len;
  logic [LEN_W-1:0] burst_src;

  seg_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (periph_req_i),
    .rise_o (req_rise)
  );

  assign burst_src = hw_q ? LEN_W'(rem_chunk_q) : rem_ublk_q;

  seg_len_pick #(.LEN_W(LEN_W), .CMD_W(CMD_W)) u_burst_pick (
    .lim_i (bmax_q),
    .rem_i (burst_src),
    .len_o (blen)
  );

  seg_len_pick #(.LEN_W(LEN_W), .CMD_W(CMD_W)) u_chunk_pick (
    .lim_i (cmax_q),
    .rem_i (rem_ublk_q),
    .len_o (chunk_len)
  );

  assign accept      = (state_q == ST_IDLE) && start_i && (ublk_len_i != '0);
  assign cmd_valid_o = (state_q == ST_ISSUE);
  assign cmd_len_o   = blen;
  assign cmd_eom_o   = cmd_valid_o && (LEN_W'(blen) == rem_ublk_q);
  assign cmd_eoc_o   = cmd_valid_o && hw_q && (blen == rem_chunk_q);
  assign fire        = cmd_valid_o && cmd_ready_i;
  assign busy_o      = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      rem_ublk_q  <= '0;
      rem_chunk_q <= '0;
      bmax_q      <= CMD_W'(1);
      cmax_q      <= CMD_W'(1);
      hw_q        <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          rem_ublk_q <= ublk_len_i;
          bmax_q     <= burst_decode(burst_sel_i);
          cmax_q     <= chunk_decode(chunk_sel_i);
          hw_q       <= hw_sync_i;
          state_q    <= hw_sync_i ? ST_WAIT : ST_ISSUE;
        end
        ST_WAIT: if (req_rise) begin
          rem_chunk_q <= chunk_len;
          state_q     <= ST_ISSUE;
        end
        ST_ISSUE: if (fire) begin
          rem_ublk_q  <= rem_ublk_q - LEN_W'(blen);
          rem_chunk_q <= rem_chunk_q - blen;
          if (cmd_eom_o)      state_q <= ST_IDLE;
          else if (cmd_eoc_o) state_q <= ST_WAIT;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_len_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (cmd_len_o != '0) && (cmd_len_o <= bmax_q));

  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_len_o)
                                    && $stable(cmd_eom_o) && $stable(cmd_eoc_o));

  p_idle_after_eom_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && cmd_eom_o |=> !busy_o);

  p_wait_after_eoc_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && cmd_eoc_o && !cmd_eom_o |=> !cmd_valid_o && busy_o);

  p_no_eoc_self_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !hw_q |-> !cmd_eoc_o);

  p_self_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && start_i && (ublk_len_i != '0) && !hw_sync_i |=> cmd_valid_o);

  p_zero_ignored_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && (!start_i || ublk_len_i == '0) |=> !busy_o);
endmodule

// File: tb/burst_chunk_seg_tb.sv
`timescale 1ns/1ps
module burst_chunk_seg_tb;
  localparam int LEN_W = 16;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             start_i = 1'b0;
  logic [LEN_W-1:0] ublk_len_i = '0;
  logic [1:0]       burst_sel_i = '0;
  logic [2:0]       chunk_sel_i = '0;
  logic             hw_sync_i = 1'b0;
  logic             periph_req_i = 1'b0;
  logic             cmd_ready_i = 1'b0;
  logic             cmd_valid_o, cmd_eoc_o, cmd_eom_o, busy_o;
  logic [4:0]       cmd_len_o;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  burst_chunk_seg #(.LEN_W(LEN_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .ublk_len_i(ublk_len_i),
    .burst_sel_i(burst_sel_i), .chunk_sel_i(chunk_sel_i), .hw_sync_i(hw_sync_i),
    .periph_req_i(periph_req_i), .cmd_ready_i(cmd_ready_i), .cmd_valid_o(cmd_valid_o),
    .cmd_len_o(cmd_len_o), .cmd_eoc_o(cmd_eoc_o), .cmd_eom_o(cmd_eom_o), .busy_o(busy_o)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int bdec(input int s);
    case (s)
      0: return 1;
      1: return 4;
      2: return 8;
      default: return 16;
    endcase
  endfunction

  function automatic int cdec(input int s);
    return (s >= 4) ? 16 : (1 << s);
  endfunction

  function automatic int min2(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  // called at a negedge; leaves at the negedge after the handshake
  task automatic take_cmd(input int el, input bit eoc, input bit eom, input int stall,
                          input string rq);
    int l0;
    for (int i = 0; i < 4 && !cmd_valid_o; i++) @(negedge clk);
    chk(cmd_valid_o, {rq, " valid"}, cmd_valid_o, 1);
    for (int i = 0; i < stall; i++) begin
      l0 = cmd_len_o;
      cmd_ready_i = 1'b0;
      @(negedge clk);
      chk(cmd_valid_o && cmd_len_o == l0, "R11 hold under stall", cmd_len_o, l0);
    end
    cmd_ready_i = 1'b1;
    chk(cmd_len_o == el, {rq, " len"}, cmd_len_o, el);
    chk(cmd_eoc_o == eoc, {rq, " eoc"}, cmd_eoc_o, eoc);
    chk(cmd_eom_o == eom, "R10 eom", cmd_eom_o, eom);
    @(negedge clk);
    cmd_ready_i = 1'b0;
  endtask

  task automatic pulse_start(input int len, input int bs, input int cs, input bit hw);
    ublk_len_i = LEN_W'(len);
    burst_sel_i = 2'(bs);
    chunk_sel_i = 3'(cs);
    hw_sync_i = hw;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic pulse_req();
    periph_req_i = 1'b1;
    @(negedge clk);
    periph_req_i = 1'b0;
  endtask

  task automatic do_job(input int len, input int bs, input int cs, input bit hw,
                        input int stall);
    int rem = len;
    int crem = 0;
    int bm = bdec(bs);
    int cm = cdec(cs);
    int e;
    pulse_start(len, bs, cs, hw);
    if (!hw) chk(cmd_valid_o, "R3 first burst next cycle", cmd_valid_o, 1);
    while (rem > 0) begin
      if (hw && crem == 0) begin
        chk(!cmd_valid_o, "R6 no cmd before request", cmd_valid_o, 0);
        @(negedge clk);
        chk(!cmd_valid_o, "R6 no cmd before request", cmd_valid_o, 0);
        pulse_req();
        crem = min2(cm, rem);
      end
      e = min2(bm, hw ? crem : rem);
      take_cmd(e, hw && (e == crem), e == rem, stall,
               hw ? "R7 chunk burst (R8 tail)" : "R4 burst (R5 tail)");
      rem -= e;
      if (hw) crem -= e;
    end
    chk(!busy_o, "R10 idle after last", busy_o, 0);
  endtask

  task automatic t_reset();
    chk(!cmd_valid_o, "R1 valid at reset", cmd_valid_o, 0);
    chk(!busy_o, "R1 busy at reset", busy_o, 0);
  endtask

  task automatic t_zero_len();
    pulse_start(0, 3, 2, 1'b0);
    chk(!busy_o, "R2 zero length ignored", busy_o, 0);
    @(negedge clk);
    chk(!cmd_valid_o, "R2 no cmd", cmd_valid_o, 0);
  endtask

  task automatic t_req_ignored();
    // len 12, burst 4, chunk 8: chunks 8,4
    pulse_start(12, 1, 3, 1'b1);
    pulse_req();
    periph_req_i = 1'b1;          // rises mid-chunk and stays high
    take_cmd(4, 1'b0, 1'b0, 0, "R9 first burst");
    take_cmd(4, 1'b1, 1'b0, 0, "R9 chunk end");
    for (int i = 0; i < 3; i++) begin
      chk(!cmd_valid_o, "R9 held request admits nothing", cmd_valid_o, 0);
      @(negedge clk);
    end
    periph_req_i = 1'b0;
    @(negedge clk);
    pulse_req();
    take_cmd(4, 1'b1, 1'b1, 0, "R8 short last chunk");
    chk(!busy_o, "R10 idle", busy_o, 0);
  endtask

  task automatic t_busy_start();
    pulse_start(20, 3, 0, 1'b0);
    ublk_len_i = LEN_W'(3);
    burst_sel_i = 2'd0;
    start_i = 1'b1;               // ignored: block busy
    @(negedge clk);
    start_i = 1'b0;
    take_cmd(16, 1'b0, 1'b0, 0, "R12 config kept");
    take_cmd(4, 1'b0, 1'b1, 0, "R12 config kept");
    chk(!busy_o, "R12 idle after original job", busy_o, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_zero_len();
    do_job(37, 2, 0, 1'b0, 2);    // 8,8,8,8,5
    do_job(3, 0, 0, 1'b0, 0);     // 1,1,1
    do_job(16, 3, 0, 1'b0, 1);    // exact 16
    do_job(21, 1, 3, 1'b1, 1);    // chunks 8,8,5 bursts of 4
    do_job(20, 3, 7, 1'b1, 0);    // chunk sel 7 -> 16, then 4
    do_job(2, 3, 0, 1'b1, 0);     // chunk 1
    do_job(10, 0, 2, 1'b1, 0);    // burst 1 inside chunk 4
    t_req_ignored();
    t_busy_start();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule